// File: doc/BRIEF.md
# Instruction Fetch Address-Match Patch Unit

This block sits on the read-data path between program memory and the CPU. It holds six programmable 24-bit detect addresses, and each one has its own enable bit. On an opcode fetch, the CPU's fetch address is compared with every enabled entry in parallel. If any enabled entry matches, the byte returned to the CPU is replaced in the same cycle by a fixed one-byte software-interrupt opcode. Firmware uses this to divert execution away from a faulty instruction held in ROM and into a patch handler.

Software programs the block over a byte-wide configuration bus. Each detect address is three individually accessible bytes: low, middle and bank. Two control bytes hold the enables, and a status byte records the first hit. Software is expected to clear an entry's enable before it rewrites that entry's address bytes.

Top module: `fetch_patch_unit`

## Requirements
- R1: Entry e (0..5) stores a 24-bit address as three bytes: config offset 3e+0 holds bits 7:0, 3e+1 holds bits 15:8 and 3e+2 holds the bank, bits 23:16. Each byte reads back as written.
- R2: Offset 18 holds the enables for entries 0, 1 and 2 in bits 0, 1 and 2. Offset 19 holds the enables for entries 3, 4 and 5 in bits 0, 1 and 2. Bits 7:3 of both bytes ignore writes and read 0.
- R3: After reset all address bytes, all enables and the status byte read 0x00, and no fetch is patched.
- R4: When fetch_opcode is 1 and fetch_addr equals the address of an enabled entry, cpu_rdata equals the trap opcode 0x01 and patch_hit is 1 in the same cycle.
- R5: When fetch_opcode is 0, cpu_rdata equals mem_rdata and patch_hit is 0, whatever the address. The status byte does not change.
- R6: A disabled entry never causes a patch, whatever address it holds.
- R7: When several enabled entries match, exactly one substitution occurs, and the status index is the lowest-numbered matching entry.
- R8: Status at offset 20 has the valid flag in bit 7 and the entry index in bits 2:0. On the clock edge after a patch, if valid was 0, it loads valid=1 and the index. While valid is 1, later patches leave the byte unchanged. Any write to offset 20 clears the byte to 0x00, and this clear takes priority over a patch in the same cycle.
- R9: A configuration write takes effect from the next clock edge. A fetch in the same cycle as the write is compared against the old contents.
- R10: Offsets 21 to 31 read 0x00, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration byte offset, used for both read and write |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for cfg_addr (combinational) |
| fetch_addr | input | 24 | CPU fetch address |
| fetch_opcode | input | 1 | High while the current read is an opcode (first-byte) fetch |
| mem_rdata | input | 8 | Byte returned by program memory |
| cpu_rdata | output | 8 | Byte delivered to the CPU, either passed through or replaced |
| patch_hit | output | 1 | High when the current fetch is being replaced |

## Verification
Fetches are driven at a programmed address in several states: with the entry disabled, with it enabled, and with the opcode strobe low. Comparing these separates a matching comparator from one that ignores the enable or the strobe. Two entries hold the same address while other entries hold their own addresses, which tells a lowest-index priority encoder apart from a highest-index or an OR-only one. Status writes that land in the same cycle as a hit, and address writes that land in the same cycle as a fetch, expose the ordering between the configuration path and the match path.

// File: rtl/patch_pkg.sv
// patch_pkg: shared constants for the fetch patch unit.
// Assumes a byte-wide configuration bus and addresses that are whole bytes.
package patch_pkg;
    localparam int BYTE_W = 8;
    localparam int CTL_REGS = 2;   // number of enable control bytes
endpackage

// File: rtl/patch_regs.sv
// patch_regs: configuration storage for the detect addresses, the enables and
// the status clear strobe, plus the combinational read-back mux.
// Assumes cfg_addr is stable during a write; unmapped offsets read zero.
module patch_regs
    import patch_pkg::*;
#(
    parameter int NUM_ENT = 6,
    parameter int ADDR_W  = 24,
    parameter int CFG_AW  = 5,
    parameter int IDX_W   = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_wr,
    input  logic [CFG_AW-1:0]         cfg_addr,
    input  logic [BYTE_W-1:0]         cfg_wdata,
    input  logic                      stat_vld,
    input  logic [IDX_W-1:0]          stat_idx,
    output logic [BYTE_W-1:0]         cfg_rdata,
    output logic [NUM_ENT*ADDR_W-1:0] ent_addr,
    output logic [NUM_ENT-1:0]        ent_en,
    output logic                      stat_clr
);
    localparam int BPA        = ADDR_W / BYTE_W;
    localparam int ADDR_BYTES = NUM_ENT * BPA;
    localparam int EPC        = (NUM_ENT + CTL_REGS - 1) / CTL_REGS;
    localparam logic [CFG_AW-1:0] OFF_EN0  = CFG_AW'(ADDR_BYTES);
    localparam logic [CFG_AW-1:0] OFF_STAT = CFG_AW'(ADDR_BYTES + CTL_REGS);

    logic [BYTE_W-1:0] byte_q [ADDR_BYTES];

    for (genvar b = 0; b < ADDR_BYTES; b++) begin : g_byte
        // Store one address byte when its offset is written.
        always_ff @(posedge clk) begin
            if (!rst_n)
                byte_q[b] <= '0;
            else if (cfg_wr && cfg_addr == CFG_AW'(b))
                byte_q[b] <= cfg_wdata;
        end
    end

    for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
        localparam logic [CFG_AW-1:0] MY_CTL = CFG_AW'(ADDR_BYTES + e / EPC);
        localparam int MY_BIT = e % EPC;
        // Store this entry's enable bit from its control byte.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ent_en[e] <= 1'b0;
            else if (cfg_wr && cfg_addr == MY_CTL)
                ent_en[e] <= cfg_wdata[MY_BIT];
        end
        for (genvar k = 0; k < BPA; k++) begin : g_part
            // Assemble the entry address from its bytes, low byte first.
            assign ent_addr[e*ADDR_W + k*BYTE_W +: BYTE_W] = byte_q[e*BPA + k];
        end
    end

    // Pulse a clear toward the status register on any write to its offset.
    assign stat_clr = cfg_wr && (cfg_addr == OFF_STAT);

    // Select the read-back byte for the addressed offset.
    always_comb begin
        cfg_rdata = '0;
        if (int'(cfg_addr) < ADDR_BYTES) begin
            cfg_rdata = byte_q[int'(cfg_addr)];
        end else if (cfg_addr == OFF_STAT) begin
            cfg_rdata[BYTE_W-1] = stat_vld;
            cfg_rdata[IDX_W-1:0] = stat_idx;
        end else begin
            for (int e = 0; e < NUM_ENT; e++) begin
                if (cfg_addr == CFG_AW'(int'(OFF_EN0) + e / EPC))
                    cfg_rdata[e % EPC] = ent_en[e];
            end
        end
    end
endmodule

// File: rtl/patch_match.sv
// patch_match: parallel address comparators and lowest-index priority encoder.
// Assumes fetch_opcode marks first-byte fetches; purely combinational.
module patch_match #(
    parameter int NUM_ENT = 6,
    parameter int ADDR_W  = 24,
    parameter int IDX_W   = 3
) (
    input  logic [NUM_ENT*ADDR_W-1:0] ent_addr,
    input  logic [NUM_ENT-1:0]        ent_en,
    input  logic [ADDR_W-1:0]         fetch_addr,
    input  logic                      fetch_opcode,
    output logic                      hit,
    output logic [IDX_W-1:0]          hit_idx
);
    logic [NUM_ENT-1:0] eq;

    for (genvar e = 0; e < NUM_ENT; e++) begin : g_cmp
        // Compare one enabled entry against a qualified opcode fetch.
        assign eq[e] = fetch_opcode && ent_en[e] &&
                       (ent_addr[e*ADDR_W +: ADDR_W] == fetch_addr);
    end

    assign hit = |eq;

    // Encode the lowest-numbered matching entry.
    always_comb begin
        hit_idx = '0;
        for (int e = NUM_ENT - 1; e >= 0; e--) begin
            if (eq[e])
                hit_idx = IDX_W'(e);
        end
    end
endmodule

// File: rtl/patch_status.sv
// patch_status: holds the first hit (valid flag and index) until software clears it.
// Assumes a clear that arrives together with a hit takes priority.
module patch_status #(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic [IDX_W-1:0] hit_idx,
    input  logic             clr,
    output logic             vld,
    output logic [IDX_W-1:0] idx
);
    // Capture the first hit and keep it until cleared.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            vld <= 1'b0;
            idx <= '0;
        end else if (hit && !vld) begin
            vld <= 1'b1;
            idx <= hit_idx;
        end
    end
endmodule

// File: rtl/fetch_patch_unit.sv
// fetch_patch_unit: replaces the opcode byte of a fetch whose address matches
// an enabled detect entry with a trap opcode, in the same cycle.
// Assumes software disables an entry while rewriting its address bytes.
module fetch_patch_unit #(
    parameter int          NUM_ENT = 6,
    parameter int          ADDR_W  = 24,
    parameter int          CFG_AW  = 5,
    parameter logic [7:0]  TRAP_OP = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              fetch_opcode,
    input  logic [7:0]        mem_rdata,
    output logic [7:0]        cpu_rdata,
    output logic              patch_hit
);
    localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;

    logic [NUM_ENT*ADDR_W-1:0] ent_addr;
    logic [NUM_ENT-1:0]        ent_en;
    logic                      stat_clr;
    logic                      stat_vld;
    logic [IDX_W-1:0]          stat_idx;
    logic                      hit;
    logic [IDX_W-1:0]          hit_idx;

    patch_regs #(.NUM_ENT(NUM_ENT), .ADDR_W(ADDR_W), .CFG_AW(CFG_AW), .IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .stat_vld(stat_vld), .stat_idx(stat_idx),
        .cfg_rdata(cfg_rdata), .ent_addr(ent_addr), .ent_en(ent_en),
        .stat_clr(stat_clr)
    );

    patch_match #(.NUM_ENT(NUM_ENT), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_match (
        .ent_addr(ent_addr), .ent_en(ent_en), .fetch_addr(fetch_addr),
        .fetch_opcode(fetch_opcode), .hit(hit), .hit_idx(hit_idx)
    );

    patch_status #(.IDX_W(IDX_W)) u_stat (
        .clk(clk), .rst_n(rst_n), .hit(hit), .hit_idx(hit_idx),
        .clr(stat_clr), .vld(stat_vld), .idx(stat_idx)
    );

    // Steer the trap opcode onto the CPU data path on a hit.
    assign cpu_rdata = hit ? TRAP_OP : mem_rdata;
    assign patch_hit = hit;
endmodule

// File: rtl/fetch_patch_chk.sv
// fetch_patch_chk: temporal checks on the patch unit, bound to its top.
module fetch_patch_chk #(
    parameter int         NUM_ENT = 6,
    parameter logic [7:0] TRAP_OP = 8'h01
) (
    input logic               clk,
    input logic               rst_n,
    input logic               fetch_opcode,
    input logic [7:0]         mem_rdata,
    input logic [7:0]         cpu_rdata,
    input logic               patch_hit,
    input logic               stat_vld,
    input logic               stat_clr,
    input logic [NUM_ENT-1:0] ent_en
);
    // R4
    trap_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        patch_hit |-> cpu_rdata == TRAP_OP);
    // R5
    no_strobe_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_opcode |-> (!patch_hit && cpu_rdata == mem_rdata));
    // R6
    all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_en == '0) |-> !patch_hit);
    // R8
    stat_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (patch_hit && !stat_clr) |=> stat_vld);
    // R8
    stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_vld && !stat_clr) |=> stat_vld);
    // R8
    stat_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_clr |=> !stat_vld);
    // R3
    rst_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (ent_en == '0 && !stat_vld));
endmodule

bind fetch_patch_unit fetch_patch_chk #(.NUM_ENT(NUM_ENT), .TRAP_OP(TRAP_OP)) u_chk (
    .clk(clk), .rst_n(rst_n), .fetch_opcode(fetch_opcode), .mem_rdata(mem_rdata),
    .cpu_rdata(cpu_rdata), .patch_hit(patch_hit), .stat_vld(stat_vld),
    .stat_clr(stat_clr), .ent_en(ent_en)
);

// File: tb/test_fetch_patch_unit.sv
// test_fetch_patch_unit: behavioural reference model compared every cycle.
module test_fetch_patch_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic [23:0] fetch_addr = '0;
    logic        fetch_opcode = 1'b0;
    logic [7:0]  mem_rdata = '0;
    logic [7:0]  cpu_rdata;
    logic        patch_hit;

    int checks = 0;
    int errors = 0;

    // Reference model state
    logic [7:0] m_b [18];
    bit   [5:0] m_en;
    bit         m_vld;
    int         m_idx;

    always #2 clk = ~clk;

    fetch_patch_unit i_fetch_patch_unit (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .fetch_addr(fetch_addr),
        .fetch_opcode(fetch_opcode), .mem_rdata(mem_rdata), .cpu_rdata(cpu_rdata),
        .patch_hit(patch_hit)
    );

    function automatic int model_find();
        for (int e = 0; e < 6; e++) begin
            if (fetch_opcode && m_en[e] &&
                {m_b[3*e+2], m_b[3*e+1], m_b[3*e]} == fetch_addr)
                return e;
        end
        return -1;
    endfunction

    function automatic logic [7:0] model_read(input int a);
        if (a < 18) return m_b[a];
        if (a == 18) return {5'b0, m_en[2:0]};
        if (a == 19) return {5'b0, m_en[5:3]};
        if (a == 20) return {m_vld, 4'b0, 3'(m_idx)};
        return 8'h00;
    endfunction

    // Advance the reference model on each rising edge.
    always @(posedge clk) begin
        int h;
        h = model_find();
        if (!rst_n) begin
            for (int i = 0; i < 18; i++) m_b[i] = 8'h00;
            m_en = '0; m_vld = 1'b0; m_idx = 0;
        end else begin
            if (cfg_wr && cfg_addr == 5'd20) begin
                m_vld = 1'b0; m_idx = 0;
            end else if (!m_vld && h >= 0) begin
                m_vld = 1'b1; m_idx = h;
            end
            if (cfg_wr) begin
                if (cfg_addr < 5'd18) m_b[cfg_addr] = cfg_wdata;
                else if (cfg_addr == 5'd18) m_en[2:0] = cfg_wdata[2:0];
                else if (cfg_addr == 5'd19) m_en[5:3] = cfg_wdata[2:0];
            end
        end
    end

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Drive one cycle of inputs, compare all outputs, move to the next falling edge.
    task automatic apply(input bit wr, input int a, input logic [7:0] wd,
                         input logic [23:0] fa, input bit fo, input logic [7:0] md,
                         input string tag);
        int h;
        cfg_wr = wr; cfg_addr = 5'(a); cfg_wdata = wd;
        fetch_addr = fa; fetch_opcode = fo; mem_rdata = md;
        #1;
        h = model_find();
        check(tag, "patch_hit", int'(patch_hit), int'(h >= 0));
        check(tag, "cpu_rdata", int'(cpu_rdata), (h >= 0) ? 8'h01 : int'(md));
        check(tag, "cfg_rdata", int'(cfg_rdata), int'(model_read(a)));
        @(negedge clk);
    endtask

    task automatic wr_entry(input int e, input logic [23:0] ad, input string tag);
        apply(1, 3*e,   ad[7:0],   24'h0, 0, 8'h5A, tag);
        apply(1, 3*e+1, ad[15:8],  24'h0, 0, 8'h5A, tag);
        apply(1, 3*e+2, ad[23:16], 24'h0, 0, 8'h5A, tag);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R3: every register reads zero and nothing is patched after reset
        for (int a = 0; a < 21; a++) apply(0, a, 8'h00, 24'h0, 1, 8'h3C, "R3");
        // R1: program every entry and read the bytes back
        for (int e = 0; e < 6; e++) wr_entry(e, 24'h10_0000 + 24'(e) * 24'h1111, "R1");
        wr_entry(2, 24'h12_3456, "R1");
        wr_entry(4, 24'h20_4000, "R1");
        wr_entry(5, 24'h20_4000, "R1");
        for (int a = 0; a < 18; a++) apply(0, a, 8'h00, 24'h0, 0, 8'h11, "R1");
        // R6: disabled entry at a matching address does not patch
        apply(0, 20, 8'h00, 24'h12_3456, 1, 8'hC3, "R6");
        // R4: enable entry 2 (offset 18 bit 2) and fetch its address
        apply(1, 18, 8'h04, 24'h12_3456, 1, 8'hC3, "R9");
        apply(0, 20, 8'h00, 24'h12_3456, 1, 8'hC3, "R4");
        apply(0, 20, 8'h00, 24'h12_3457, 1, 8'hC4, "R4");
        // R5: same address without the opcode strobe passes through
        apply(0, 20, 8'h00, 24'h12_3456, 0, 8'h77, "R5");
        // R2: upper bits of control bytes read zero
        apply(1, 18, 8'hFC, 24'h0, 0, 8'h00, "R2");
        apply(0, 18, 8'h00, 24'h12_3456, 1, 8'h99, "R2");
        apply(1, 19, 8'hF8, 24'h0, 0, 8'h00, "R2");
        apply(0, 19, 8'h00, 24'h20_4000, 1, 8'h99, "R2");
        // R7: entries 4 and 5 share an address, both enabled
        apply(1, 20, 8'h00, 24'h0, 0, 8'h00, "R8");
        apply(1, 19, 8'h06, 24'h0, 0, 8'h00, "R7");
        apply(0, 20, 8'h00, 24'h20_4000, 1, 8'h42, "R7");
        apply(0, 20, 8'h00, 24'h0, 0, 8'h42, "R7");
        // R8: a later hit on another entry leaves status alone
        apply(1, 18, 8'h01, 24'h0, 0, 8'h00, "R8");
        apply(0, 20, 8'h00, 24'h10_0000, 1, 8'h21, "R8");
        apply(0, 20, 8'h00, 24'h0, 0, 8'h21, "R8");
        // R8: clear in the same cycle as a hit wins
        apply(1, 20, 8'h00, 24'h10_0000, 1, 8'h21, "R8");
        apply(0, 20, 8'h00, 24'h0, 0, 8'h21, "R8");
        apply(0, 20, 8'h00, 24'h10_0000, 1, 8'h21, "R8");
        apply(0, 20, 8'h00, 24'h0, 0, 8'h21, "R8");
        // R9: address write lands at the next edge
        apply(1, 0, 8'h20, 24'h10_0020, 1, 8'h66, "R9");
        apply(0, 20, 8'h00, 24'h10_0020, 1, 8'h66, "R9");
        apply(0, 20, 8'h00, 24'h10_0000, 1, 8'h67, "R9");
        // R10: unmapped offsets read zero and writes change nothing
        for (int a = 21; a < 32; a++) apply(1, a, 8'hFF, 24'h0, 0, 8'h00, "R10");
        for (int a = 21; a < 32; a++) apply(0, a, 8'h00, 24'h10_0020, 1, 8'h12, "R10");
        for (int a = 0; a < 21; a++) apply(0, a, 8'h00, 24'h0, 0, 8'h00, "R10");
        finish_run();
    end
endmodule